// File: doc/BRIEF.md
# FIFO-Fed Asynchronous Serial Transmitter

This block drains bytes from a FIFO that sits outside it and sends each one as an asynchronous serial frame on a single output line. It watches the FIFO's empty flag and issues a one-cycle read request. It then waits for the FIFO to mark the returned word as valid, registers that word into a frame shift register and shifts the frame out one bit period at a time. A free-running divider of `CLK_PER_BIT` system clocks sets the length of each bit period.

A frame is a low start bit, `DATA_BITS` data bits (5 to 8) sent least significant bit first, an optional parity bit of selectable polarity, and one high stop bit. The frame shape is fixed by parameters at build time. A small three-state controller (idle, load, shift) sequences the work. When the FIFO still holds data at the end of a stop bit, the controller goes straight on to fetch the next word, so back-to-back frames are separated only by the FIFO's read latency.

Top module: `fifo_serial_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `txd` is 1, `fifo_rd_req` is 0 and `busy` is 0.
- R2: While idle with `fifo_empty` high, the block issues no read request and `txd` stays 1.
- R3: When idle and `fifo_empty` is seen low at a clock edge, `fifo_rd_req` is high for exactly one cycle, starting in the cycle after that edge. No further request is issued until the frame of the requested word has ended.
- R4: The word sent is the value on `fifo_rd_data` in the cycle where `fifo_rd_valid` is high. The bus is ignored in every other cycle, and bits at or above `DATA_BITS` are never sent.
- R5: A frame is a start bit of 0 in position 0, followed by data bit k in position k+1 (LSB first). Each position is held on `txd` for exactly `CLK_PER_BIT` cycles, and the start bit begins in the cycle after `fifo_rd_valid` is sampled.
- R6: With `PARITY_EN`=1, a parity bit follows the last data bit (position `DATA_BITS`+1). With `PARITY_ODD`=0 the data and parity bits together hold an even number of ones; with `PARITY_ODD`=1 they hold an odd number.
- R7: Every frame ends with a stop bit of 1 held for a full `CLK_PER_BIT` cycles, whatever the FIFO does during it.
- R8: At the end of a stop bit the block fetches the next word if `fifo_empty` is low. With a FIFO that answers one cycle after the request, consecutive start bits are `FRAME_LEN*CLK_PER_BIT`+2 cycles apart. If `fifo_empty` is high, the block returns to idle.
- R9: `busy` is 1 from the cycle the read request is issued until the end of the stop bit, and it is 1 during every bit of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd_req | output | 1 | One-cycle read request to the FIFO |
| fifo_rd_valid | input | 1 | FIFO read data is valid this cycle |
| fifo_rd_data | input | 8 | FIFO read data; low `DATA_BITS` bits are sent |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A word is being fetched or sent |

## Verification
The assertions assume that the FIFO answers each request with exactly one `fifo_rd_valid` pulse at least one cycle later, and that it raises valid at no other time. They also assume that `fifo_empty` describes the FIFO's contents after any read already answered. The bench models such a FIFO with a queue. Its read latency is drawn at random from one to three cycles, and it drives random garbage on the data bus whenever valid is low. Writes into the queue are timed at random so that refills land inside frames, at stop-bit boundaries and during idle stretches.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int WORD_W    = 8;
    localparam int FRAME_MAX = WORD_W + 3;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [FRAME_MAX-1:0] frame_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic load;
        logic shift;
    } shift_cmd_t;

    function automatic int frame_len(int nbits, bit par_en);
        return nbits + (par_en ? 1 : 0) + 2;
    endfunction

    function automatic logic parity_of(word_t w, int nbits, bit odd);
        logic p;
        p = odd;
        for (int i = 0; i < WORD_W; i++)
            if (i < nbits) p = p ^ w[i];
        return p;
    endfunction

    // start bit at position 0, data LSB first, optional parity, stop bit(s) high
    function automatic frame_t pack_frame(word_t w, int nbits, bit par_en, bit odd);
        frame_t f;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < WORD_W; i++)
            if (i < nbits) f[i+1] = w[i];
        if (par_en) f[nbits+1] = parity_of(w, nbits, odd);
        return f;
    endfunction

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
    parameter int CLK_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_BIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
    import ser_tx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  shift_cmd_t cmd,
    input  word_t      word,
    output logic       bit_out
);
    localparam int FLEN = frame_len(DATA_BITS, PARITY_EN);

    frame_t          packed_f;
    logic [FLEN-1:0] sr;

    always_comb packed_f = pack_frame(word, DATA_BITS, PARITY_EN, PARITY_ODD);

    always_ff @(posedge clk) begin
        if (rst)            sr <= '1;
        else if (cmd.load)  sr <= packed_f[FLEN-1:0];
        else if (cmd.shift) sr <= {1'b1, sr[FLEN-1:1]};
    end

    assign bit_out = sr[0];
endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
    import ser_tx_pkg::*;
#(
    parameter int LAST_POS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    input  logic       word_valid,
    input  logic       tick,
    output tx_state_e  state,
    output logic       rd_req,
    output shift_cmd_t cmd
);
    localparam int POS_W = $clog2(LAST_POS + 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(LAST_POS);

    tx_state_e        state_n;
    logic [POS_W-1:0] pos;

    always_comb begin
        state_n = state;
        cmd     = '0;
        unique case (state)
            ST_IDLE:  if (!fifo_empty) state_n = ST_LOAD;
            ST_LOAD:  if (word_valid) begin
                          cmd.load = 1'b1;
                          state_n  = ST_SHIFT;
                      end
            ST_SHIFT: if (tick) begin
                          cmd.shift = 1'b1;
                          if (pos == POS_END)
                              state_n = fifo_empty ? ST_IDLE : ST_LOAD;
                      end
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            rd_req <= 1'b0;
            pos    <= '0;
        end else begin
            state  <= state_n;
            rd_req <= (state_n == ST_LOAD) && (state != ST_LOAD);
            if (cmd.load)       pos <= '0;
            else if (cmd.shift) pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/fifo_serial_tx.sv
module fifo_serial_tx
    import ser_tx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter bit PARITY_EN   = 1'b1,
    parameter bit PARITY_ODD  = 1'b0,
    parameter int CLK_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    output logic       fifo_rd_req,
    input  logic       fifo_rd_valid,
    input  logic [7:0] fifo_rd_data,
    output logic       txd,
    output logic       busy
);
    localparam int LAST_POS = DATA_BITS + (PARITY_EN ? 1 : 0) + 1;

    tx_state_e  state;
    shift_cmd_t cmd;
    logic       tick;
    logic       bit_out;

    ser_tx_ctrl #(.LAST_POS(LAST_POS)) u_ctrl (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .word_valid(fifo_rd_valid),
        .tick(tick), .state(state), .rd_req(fifo_rd_req), .cmd(cmd)
    );

    ser_tx_baud #(.CLK_PER_BIT(CLK_PER_BIT)) u_baud (
        .clk(clk), .rst(rst), .run(state == ST_SHIFT), .tick(tick)
    );

    ser_tx_shifter #(
        .DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
    ) u_shift (
        .clk(clk), .rst(rst), .cmd(cmd), .word(fifo_rd_data), .bit_out(bit_out)
    );

    assign txd  = (state == ST_SHIFT) ? bit_out : 1'b1;
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker (
    input logic clk,
    input logic rst,
    input logic fifo_empty,
    input logic fifo_rd_req,
    input logic txd,
    input logic busy
);
    // R5: line rests high whenever no frame is in progress
    p_idle_line_high_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R3: a read request lasts one cycle
    p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_req |=> !fifo_rd_req);

    // R2: idle with an empty FIFO never requests
    p_no_req_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && fifo_empty) |=> !fifo_rd_req);

    // R9: leaving idle coincides with the request
    p_busy_with_req_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> fifo_rd_req);

    // R8: requests only occur while the block is engaged
    p_req_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_req |-> busy);

    // R7: the last bit before returning to idle is a high stop bit
    p_stop_before_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(txd));
endmodule

bind fifo_serial_tx ser_tx_checker u_chk (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty),
    .fifo_rd_req(fifo_rd_req), .txd(txd), .busy(busy)
);

// File: tb/fifo_serial_tx_bench.sv
module fifo_serial_tx_bench;
    localparam int CLK_P = 10;
    localparam int DB    = 7;
    localparam bit PE    = 1'b1;
    localparam bit ODD   = 1'b1;
    localparam int CPB   = 6;
    localparam int FLEN  = DB + (PE ? 1 : 0) + 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_empty = 1'b1;
    logic       fifo_rd_req;
    logic       fifo_rd_valid = 1'b0;
    logic [7:0] fifo_rd_data = 8'h00;
    logic       txd;
    logic       busy;

    fifo_serial_tx #(.DATA_BITS(DB), .PARITY_EN(PE), .PARITY_ODD(ODD), .CLK_PER_BIT(CPB))
    u_fifo_serial_tx (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_rd_req(fifo_rd_req),
        .fifo_rd_valid(fifo_rd_valid), .fifo_rd_data(fifo_rd_data), .txd(txd), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int cyc = 0, frames = 0, n_req = 0, req_err = 0;
    int lat_min = 1, lat_max = 1;
    logic [7:0] fifo_q[$];
    logic [7:0] exp_q[$];
    int starts[$];
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(logic [7:0] d, int i);
        if (i == 0) return 1'b0;
        if (i <= DB) return d[i-1];
        if (PE && i == DB + 1) return (^d[DB-1:0]) ^ ODD;
        return 1'b1;
    endfunction

    initial forever begin @(posedge clk); cyc++; end

    // FIFO model: random latency, garbage on the bus when not valid
    initial begin
        int cnt = 0;
        bit prev_req = 0;
        forever begin
            @(negedge clk);
            fifo_rd_valid = 1'b0;
            fifo_rd_data  = 8'($urandom);
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0 && fifo_q.size() > 0) begin
                    fifo_rd_data  = fifo_q.pop_front();
                    fifo_rd_valid = 1'b1;
                    exp_q.push_back(fifo_rd_data);
                end
            end
            if (!rst && fifo_rd_req) begin
                n_req++;
                if (prev_req || cnt > 0 || fifo_q.size() == 0) req_err++; // R3
                cnt = lat_min + int'($urandom % (lat_max - lat_min + 1));
            end
            prev_req   = !rst && fifo_rd_req;
            fifo_empty = (fifo_q.size() == 0);
        end
    end

    // line monitor: every cycle of every bit position is compared
    initial forever begin
        @(negedge clk);
        if (!rst && txd === 1'b0) begin
            logic [7:0] d;
            starts.push_back(cyc);
            chk(exp_q.size() > 0, "R4", "frame without a valid word", 0, 1);
            d = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            for (int i = 0; i < FLEN; i++) begin
                int bad = 0;
                for (int j = 0; j < CPB; j++) begin
                    if (i > 0 || j > 0) @(negedge clk);
                    if (txd !== exp_bit(d, i) || busy !== 1'b1) bad++;
                end
                if (i == 0 || i <= DB) chk(bad == 0, "R5", $sformatf("bit %0d of word %02h", i, d), bad, 0);
                else if (PE && i == DB + 1) chk(bad == 0, "R6", $sformatf("parity of word %02h", d), bad, 0);
                else chk(bad == 0, "R7", $sformatf("stop of word %02h", d), bad, 0);
            end
            frames++;
        end
    end

    task automatic push(logic [7:0] v);
        @(posedge clk); #1;
        fifo_q.push_back(v);
    endtask

    task automatic wait_drain();
        int guard = 0;
        while ((fifo_q.size() > 0 || exp_q.size() > 0 || busy) && guard < 20000) begin
            @(posedge clk); guard++;
        end
        repeat (4) @(posedge clk);
    endtask

    initial begin
        int total;
        void'($urandom(32'h5EED));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(txd === 1'b1 && fifo_rd_req === 1'b0 && busy === 1'b0, "R1", "during reset",
            {txd, fifo_rd_req, busy}, 3'b100);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1 && fifo_rd_req === 1'b0 && busy === 1'b0, "R1", "after release",
            {txd, fifo_rd_req, busy}, 3'b100);

        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (fifo_rd_req !== 1'b0 || txd !== 1'b1) seen++;
            end
            chk(seen == 0, "R2", "activity while empty", seen, 0);
        end

        // directed back-to-back, bytes with bit 7 set to test masking (R4)
        lat_min = 1; lat_max = 1;
        starts.delete();
        @(posedge clk); #1;
        fifo_q.push_back(8'hD5); fifo_q.push_back(8'h80); fifo_q.push_back(8'h7F);
        wait_drain();
        chk(frames == 3, "R8", "frames sent back to back", frames, 3);
        if (starts.size() == 3) begin
            chk(starts[1] - starts[0] == FLEN*CPB + 2, "R8", "start spacing 1",
                starts[1] - starts[0], FLEN*CPB + 2);
            chk(starts[2] - starts[1] == FLEN*CPB + 2, "R8", "start spacing 2",
                starts[2] - starts[1], FLEN*CPB + 2);
        end
        @(negedge clk);
        chk(busy === 1'b0 && txd === 1'b1, "R9", "idle after drain", {busy, txd}, 2'b01);

        // single word with a refill pushed during its stop bit
        push(8'h01);
        repeat (2 + (FLEN - 1) * CPB + 2) @(posedge clk);
        #1 fifo_q.push_back(8'hFE);
        wait_drain();
        chk(frames == 5, "R7", "refill during stop bit", frames, 5);

        // random traffic
        lat_min = 1; lat_max = 3;
        for (int n = 0; n < 60; n++) begin
            push(8'($urandom));
            repeat ($urandom % 90) @(posedge clk);
        end
        wait_drain();
        total = 65;
        chk(frames == total, "R4", "frames after random traffic", frames, total);
        chk(n_req == frames, "R3", "requests equal frames", n_req, frames);
        chk(req_err == 0, "R3", "request protocol errors", req_err, 0);
        chk(exp_q.size() == 0, "R5", "words left unsent", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            chk(1'b0, "R9", "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule